// File: doc/BRIEF.md
# Extended parallel port interrupt request generator

This block turns the status of an extended-capabilities parallel port into a single host interrupt request line. It watches five sources of interrupt: the DMA terminal count, a FIFO space threshold while the port transmits, a FIFO fill threshold while the port receives, the printer error pin and the printer acknowledge pin. Each source is qualified by the current control register fields: the service-interrupt bit, the DMA enable, the error-interrupt disable, the three-bit operating mode, the transfer direction and the acknowledge interrupt enable.

The terminal count is a pulse source and raises one request in every cycle it is qualified. The two FIFO thresholds and the error condition are level sources. Each is shaped so that only the cycle in which its condition becomes true raises a one-cycle event. Clearing the service bit while a threshold already holds therefore counts as a new event. All sources are masked while the port clock is frozen, and a level that becomes true during a freeze is not reported later. The error and acknowledge pins pass through a two-flop synchronizer before edge detection.

Two output-control bits select how events reach the pin. With both at 0, the line follows the synchronized acknowledge pin whenever the acknowledge interrupt is enabled, with any event pulse added. The other three settings give a held request, a one-cycle active-low pulse or a one-cycle active-high pulse. The block has no data stream, so it has no valid/ready handshake: every port is a plain control or status pin.

Top module: `ecp_irq_gen`

## Requirements
- R1: With `svc_hold`=0 and `dma_on`=1, a cycle with `dma_tc`=1 produces an event, and the IRQ output reflects it on the next clock edge. With `dma_on`=0, `dma_tc` produces no event.
- R2: With `svc_hold`=0, `dma_on`=0, `dir_rx`=0 and `port_mode` equal to 3'b010, 3'b011 or 3'b110, an event occurs when `fifo_free` becomes at least 8. In any other mode, for example 3'b001, there is no event.
- R3: With `svc_hold`=0, `dma_on`=0, `dir_rx`=1 and `port_mode` equal to 3'b011 or 3'b110, an event occurs when `fifo_fill` becomes at least 8. Mode 3'b010 gives no event.
- R4: If a FIFO threshold already holds while `svc_hold`=1, lowering `svc_hold` to 0 produces one event.
- R5: With `err_mask`=0, a high-to-low change on `err_n` produces an event three edges after the pin changes: two synchronizer stages and the output register. If `err_n` is already low, a change of `err_mask` from 1 to 0 produces an event one edge later.
- R6: With `ack_ie`=1, a low-to-high change on `ack_n` produces an event three edges after the pin changes. With `ack_ie`=0, `ack_n` changes produce none.
- R7: A level source (FIFO space, FIFO fill or error) that stays true gives exactly one event, one clock long.
- R8: While `clk_frozen`=1, no event is produced. A level that becomes true during the freeze is not reported after the freeze ends.
- R9: Output code {`out_pulse`,`out_hi`}=2'b00: the IRQ line equals (`ack_ie` AND synchronized `ack_n`) OR event, with three edges of latency from the pin.
- R10: Code 2'b11: the IRQ line is high for exactly the cycles after events and low otherwise. Code 2'b10: the same, inverted, so the line idles high.
- R11: Code 2'b01: the IRQ line goes high after an event and stays high until `svc_hold`=1 is seen, and is low on the following edge.
- R12: During and right after reset the IRQ line is low and both synchronizers read the pins as idle high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low synchronous reset |
| svc_hold | input | 1 | Service-interrupt bit; 1 blocks FIFO and count events and clears a held request |
| dma_on | input | 1 | DMA enable |
| err_mask | input | 1 | Error-interrupt disable |
| port_mode | input | 3 | Operating mode field |
| dir_rx | input | 1 | Transfer direction, 1 = receive |
| ack_ie | input | 1 | Acknowledge interrupt enable |
| out_pulse | input | 1 | Output control: 1 = pulse output |
| out_hi | input | 1 | Output control: active-high select / held mode |
| dma_tc | input | 1 | DMA terminal count, asserted inside a DMA cycle |
| fifo_free | input | CNT_W | Free byte count of the FIFO |
| fifo_fill | input | CNT_W | Readable byte count of the FIFO |
| err_n | input | 1 | Asynchronous printer error pin, low = error |
| ack_n | input | 1 | Asynchronous printer acknowledge pin |
| clk_frozen | input | 1 | Port clock frozen, masks all events |
| irq | output | 1 | Interrupt request line |

## Verification
The assertions assume that `err_n` and `ack_n` may change at any time, and that every other input is synchronous and held stable around the rising edge. They also assume that `out_pulse`/`out_hi` stay constant for the cycle before an edge whose output they judge. The bench drives every input on the falling clock edge. It changes the output code only while no event is pending, and it holds each pin level for at least three edges, so the synchronizer latency is always honoured before a result is sampled.

// File: rtl/ecp_irq_pkg.sv
package ecp_irq_pkg;

  // output behaviour selected by {pulse, hi}
  typedef enum logic [1:0] {
    OUT_FOLLOW   = 2'b00,
    OUT_HELD     = 2'b01,
    OUT_PULSE_LO = 2'b10,
    OUT_PULSE_HI = 2'b11
  } out_sel_e;

  // modes in which the transmit space threshold counts
  function automatic logic tx_mode_ok(input logic [2:0] m);
    return (m == 3'b010) || (m == 3'b011) || (m == 3'b110);
  endfunction

  // modes in which the receive fill threshold counts
  function automatic logic rx_mode_ok(input logic [2:0] m);
    return (m == 3'b011) || (m == 3'b110);
  endfunction

endpackage

// File: rtl/ecp_pin_sync.sv
module ecp_pin_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= IDLE;
          else        chain[0] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= IDLE;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

  // R12
  idle_after_reset_chk: assert property (@(posedge clk)
    !rst_n |=> (q == IDLE));

endmodule

// File: rtl/ecp_evt_detect.sv
module ecp_evt_detect
  import ecp_irq_pkg::*;
#(
  parameter int CNT_W  = 5,
  parameter int THRESH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             svc_hold,
  input  logic             dma_on,
  input  logic             err_mask,
  input  logic [2:0]       port_mode,
  input  logic             dir_rx,
  input  logic             ack_ie,
  input  logic             dma_tc,
  input  logic [CNT_W-1:0] fifo_free,
  input  logic [CNT_W-1:0] fifo_fill,
  input  logic             err_s,
  input  logic             ack_s,
  input  logic             clk_frozen,
  output logic             evt
);
  localparam logic [CNT_W-1:0] THR = CNT_W'(THRESH);

  logic fifo_path;
  logic tx_lvl, rx_lvl, err_lvl;
  logic tx_q, rx_q, err_q, ack_q;
  logic tc_e, tx_e, rx_e, err_e, ack_e;

  assign fifo_path = !svc_hold && !dma_on;
  assign tx_lvl  = fifo_path && !dir_rx && tx_mode_ok(port_mode) && (fifo_free >= THR);
  assign rx_lvl  = fifo_path &&  dir_rx && rx_mode_ok(port_mode) && (fifo_fill >= THR);
  assign err_lvl = !err_mask && !err_s;

  // level history for edge shaping; keeps tracking through a freeze
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q  <= 1'b0;
      rx_q  <= 1'b0;
      err_q <= 1'b0;
      ack_q <= 1'b1;
    end else begin
      tx_q  <= tx_lvl;
      rx_q  <= rx_lvl;
      err_q <= err_lvl;
      ack_q <= ack_s;
    end
  end

  assign tc_e  = !svc_hold && dma_on && dma_tc;
  assign tx_e  = tx_lvl && !tx_q;
  assign rx_e  = rx_lvl && !rx_q;
  assign err_e = err_lvl && !err_q;
  assign ack_e = ack_ie && ack_s && !ack_q;

  assign evt = !clk_frozen && (tc_e || tx_e || rx_e || err_e || ack_e);

  // R7
  tx_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_e |=> !tx_e);
  // R7
  rx_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_e |=> !rx_e);
  // R7
  err_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_e |=> !err_e);

endmodule

// File: rtl/ecp_irq_shape.sv
module ecp_irq_shape
  import ecp_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  out_sel_e sel,
  input  logic     svc_hold,
  input  logic     ack_ie,
  input  logic     ack_s,
  input  logic     evt,
  output logic     irq
);
  logic held_q, held_d;
  logic irq_d;

  assign held_d = svc_hold ? 1'b0 : (held_q || evt);

  always_comb begin
    unique case (sel)
      OUT_FOLLOW:   irq_d = (ack_ie && ack_s) || evt;
      OUT_HELD:     irq_d = held_d;
      OUT_PULSE_LO: irq_d = !evt;
      default:      irq_d = evt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      held_q <= held_d;
      irq    <= irq_d;
    end
  end

  // R11
  held_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == OUT_HELD && svc_hold) |=> !irq);
  // R10
  quiet_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == OUT_PULSE_HI && !evt) |=> !irq);
  // R10
  quiet_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == OUT_PULSE_LO && !evt) |=> irq);
  // R9
  follow_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == OUT_FOLLOW && !ack_ie && !evt) |=> !irq);

endmodule

// File: rtl/ecp_irq_gen.sv
module ecp_irq_gen
  import ecp_irq_pkg::*;
#(
  parameter int CNT_W       = 5,
  parameter int THRESH      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             svc_hold,
  input  logic             dma_on,
  input  logic             err_mask,
  input  logic [2:0]       port_mode,
  input  logic             dir_rx,
  input  logic             ack_ie,
  input  logic             out_pulse,
  input  logic             out_hi,
  input  logic             dma_tc,
  input  logic [CNT_W-1:0] fifo_free,
  input  logic [CNT_W-1:0] fifo_fill,
  input  logic             err_n,
  input  logic             ack_n,
  input  logic             clk_frozen,
  output logic             irq
);
  localparam int NPINS = 2;

  logic [NPINS-1:0] pins_raw, pins_s;
  logic evt;
  out_sel_e sel;

  assign pins_raw = {ack_n, err_n};
  assign sel      = out_sel_e'({out_pulse, out_hi});

  genvar p;
  generate
    for (p = 0; p < NPINS; p++) begin : g_sync
      ecp_pin_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (pins_raw[p]),
        .q    (pins_s[p])
      );
    end
  endgenerate

  ecp_evt_detect #(.CNT_W(CNT_W), .THRESH(THRESH)) u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .svc_hold  (svc_hold),
    .dma_on    (dma_on),
    .err_mask  (err_mask),
    .port_mode (port_mode),
    .dir_rx    (dir_rx),
    .ack_ie    (ack_ie),
    .dma_tc    (dma_tc),
    .fifo_free (fifo_free),
    .fifo_fill (fifo_fill),
    .err_s     (pins_s[0]),
    .ack_s     (pins_s[1]),
    .clk_frozen(clk_frozen),
    .evt       (evt)
  );

  ecp_irq_shape u_shape (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (sel),
    .svc_hold(svc_hold),
    .ack_ie  (ack_ie),
    .ack_s   (pins_s[1]),
    .evt     (evt),
    .irq     (irq)
  );

  // R8
  frozen_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_frozen && out_pulse && out_hi) |=> !irq);
  // R12
  reset_low_chk: assert property (@(posedge clk)
    !rst_n |=> !irq);

endmodule

// File: tb/test_ecp_irq_gen.sv
module test_ecp_irq_gen;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic svc_hold, dma_on, err_mask, dir_rx, ack_ie, out_pulse, out_hi;
  logic dma_tc, err_n, ack_n, clk_frozen;
  logic [2:0] port_mode;
  logic [CNT_W-1:0] fifo_free, fifo_fill;
  logic irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecp_irq_gen #(.CNT_W(CNT_W)) i_ecp_irq_gen (
    .clk(clk), .rst_n(rst_n), .svc_hold(svc_hold), .dma_on(dma_on),
    .err_mask(err_mask), .port_mode(port_mode), .dir_rx(dir_rx),
    .ack_ie(ack_ie), .out_pulse(out_pulse), .out_hi(out_hi),
    .dma_tc(dma_tc), .fifo_free(fifo_free), .fifo_fill(fifo_fill),
    .err_n(err_n), .ack_n(ack_n), .clk_frozen(clk_frozen), .irq(irq)
  );

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(string req, logic exp);
    total++;
    if (irq !== exp) begin
      bad++;
      $display("FAIL %s: irq=%b expected=%b at %0t", req, irq, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    svc_hold = 1'b1; dma_on = 1'b0; err_mask = 1'b1; port_mode = 3'b000;
    dir_rx = 1'b0; ack_ie = 1'b0; out_pulse = 1'b1; out_hi = 1'b1;
    dma_tc = 1'b0; fifo_free = '0; fifo_fill = '0; err_n = 1'b1;
    ack_n = 1'b1; clk_frozen = 1'b0;
  endtask

  task automatic t_reset();
    idle_inputs();
    rst_n = 1'b0;
    step(3);
    chk("R12 in reset", 1'b0);
    rst_n = 1'b1;
    step(4);
    chk("R12 after reset", 1'b0);
  endtask

  task automatic t_tc();
    svc_hold = 1'b0; dma_on = 1'b1; dma_tc = 1'b1;
    step(); chk("R1 tc event", 1'b1);
    dma_tc = 1'b0;
    step(); chk("R1 tc ended", 1'b0);
    dma_on = 1'b0; dma_tc = 1'b1;
    step(); chk("R1 tc without dma", 1'b0);
    dma_tc = 1'b0; svc_hold = 1'b1; step();
  endtask

  task automatic t_tx_thr();
    svc_hold = 1'b0; port_mode = 3'b010; dir_rx = 1'b0; fifo_free = 5'd8;
    step(); chk("R2 tx threshold", 1'b1);
    step(); chk("R7 tx single pulse", 1'b0);
    step(); chk("R7 tx stays quiet", 1'b0);
    fifo_free = 5'd7; step();
    fifo_free = 5'd12;
    step(); chk("R2 tx threshold again", 1'b1);
    fifo_free = 5'd0; port_mode = 3'b001; step();
    fifo_free = 5'd8;
    step(); chk("R2 tx wrong mode", 1'b0);
    fifo_free = 5'd0; svc_hold = 1'b1; port_mode = 3'b000; step();
  endtask

  task automatic t_rx_thr();
    svc_hold = 1'b0; port_mode = 3'b110; dir_rx = 1'b1; fifo_fill = 5'd8;
    step(); chk("R3 rx threshold", 1'b1);
    fifo_fill = 5'd0; port_mode = 3'b010; step();
    fifo_fill = 5'd9;
    step(); chk("R3 rx wrong mode", 1'b0);
    fifo_fill = 5'd0; dir_rx = 1'b0; svc_hold = 1'b1; port_mode = 3'b000; step();
  endtask

  task automatic t_svc_clear();
    port_mode = 3'b011; fifo_free = 5'd10;
    step(); chk("R4 blocked by svc", 1'b0);
    svc_hold = 1'b0;
    step(); chk("R4 svc cleared", 1'b1);
    step(); chk("R7 after svc clear", 1'b0);
    svc_hold = 1'b1; fifo_free = 5'd0; port_mode = 3'b000; step();
  endtask

  task automatic t_err();
    err_mask = 1'b0; err_n = 1'b0;
    step(); chk("R5 err sync stage 1", 1'b0);
    step(); chk("R5 err sync stage 2", 1'b0);
    step(); chk("R5 err falling edge", 1'b1);
    step(); chk("R7 err single pulse", 1'b0);
    err_n = 1'b1; step(3);
    err_mask = 1'b1; err_n = 1'b0; step(3);
    chk("R5 err masked", 1'b0);
    err_mask = 1'b0;
    step(); chk("R5 unmask while low", 1'b1);
    err_n = 1'b1; err_mask = 1'b1; step(3);
  endtask

  task automatic t_ack();
    ack_ie = 1'b1; ack_n = 1'b0; step(3);
    chk("R6 ack falling ignored", 1'b0);
    ack_n = 1'b1;
    step(2); chk("R6 ack in sync", 1'b0);
    step(); chk("R6 ack rising edge", 1'b1);
    step(); chk("R6 ack single pulse", 1'b0);
    ack_ie = 1'b0; ack_n = 1'b0; step(3);
    ack_n = 1'b1;
    step(3); chk("R6 ack disabled", 1'b0);
  endtask

  task automatic t_freeze();
    clk_frozen = 1'b1; svc_hold = 1'b0; dma_on = 1'b1; dma_tc = 1'b1;
    step(); chk("R8 tc frozen", 1'b0);
    dma_tc = 1'b0; dma_on = 1'b0; port_mode = 3'b010; fifo_free = 5'd8;
    step(); chk("R8 tx frozen", 1'b0);
    clk_frozen = 1'b0;
    step(); chk("R8 event lost after freeze", 1'b0);
    fifo_free = 5'd0; port_mode = 3'b000; svc_hold = 1'b1; step();
  endtask

  task automatic t_pulse_low();
    out_pulse = 1'b1; out_hi = 1'b0;
    step(); chk("R10 low idle high", 1'b1);
    svc_hold = 1'b0; dma_on = 1'b1; dma_tc = 1'b1;
    step(); chk("R10 low pulse", 1'b0);
    dma_tc = 1'b0;
    step(); chk("R10 low pulse end", 1'b1);
    dma_on = 1'b0; svc_hold = 1'b1; out_hi = 1'b1; step();
  endtask

  task automatic t_held();
    out_pulse = 1'b0; out_hi = 1'b1; step();
    svc_hold = 1'b0; dma_on = 1'b1; dma_tc = 1'b1;
    step(); chk("R11 held set", 1'b1);
    dma_tc = 1'b0;
    step(2); chk("R11 held kept", 1'b1);
    svc_hold = 1'b1;
    step(); chk("R11 held cleared", 1'b0);
    dma_on = 1'b0; out_pulse = 1'b1; step();
  endtask

  task automatic t_follow();
    out_pulse = 1'b0; out_hi = 1'b0; ack_ie = 1'b1;
    step(); chk("R9 follow ack high", 1'b1);
    ack_n = 1'b0;
    step(2); chk("R9 follow latency", 1'b1);
    step(); chk("R9 follow ack low", 1'b0);
    ack_n = 1'b1;
    step(3); chk("R9 follow ack back", 1'b1);
    ack_ie = 1'b0;
    step(); chk("R9 follow disabled", 1'b0);
    out_pulse = 1'b1; out_hi = 1'b1; step();
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_tc();
    t_tx_thr();
    t_rx_thr();
    t_svc_clear();
    t_err();
    t_ack();
    t_freeze();
    t_pulse_low();
    t_held();
    t_follow();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule